// File: doc/BRIEF.md
# Address Match Breakpoint Unit

This unit watches the address bus of a processor core and requests a debug break when the bus carries an address that software has programmed. The break address is kept as two byte-wide registers. Each byte goes to its own 8-bit equality comparator. A third register holds an enable bit, a break-active bit and a flag-clear-enable bit. Software can set the break-active bit by hand to force a break with no address match.

A request is never acted on in the middle of an instruction. It waits until the core signals an instruction boundary. At that boundary the unit raises a one-cycle request to inject a software-interrupt opcode. With that pulse it gives the vector address to fetch and a marker that tells the core what the matched address was. The marker is high when the matched address was the opcode fetch of the next instruction. That instruction is then dropped, and it resumes only after the break routine returns. The marker is low when the match was on an operand of the current instruction, which has already completed. The unit stays in the break state until the core reports the return-from-interrupt. While in break it ignores new requests, and it blocks status-clearing side effects unless the flag-clear-enable bit is set.

Top module: `addr_brkpt_unit`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `swi_inject`, `resume_at_fetch` and `in_break` are 0. `flag_clr_allow` is 1 and `vector_addr` is 0xFFFC.
- R2: Register offset 0 holds the high byte of the break address and offset 1 holds the low byte. Offset 2 is the control register: bit 0 is enable, bit 1 is break-active and bit 2 is flag-clear-enable, with bits 7:3 reading 0. Offset 3 reads 0 and ignores writes. Reads are combinational from `reg_addr`.
- R3: A hit needs `cpu_addr_valid` = 1, enable = 1, and both address bytes equal to their registers. A hit sets break-active. An address that differs in either byte alone gives no hit.
- R4: With enable = 0, matching addresses raise no break and leave break-active at 0.
- R5: A request is taken at the first clock edge where `instr_end` = 1, counting the request's own cycle. `swi_inject` is then high for exactly the following cycle.
- R6: `resume_at_fetch` pulses together with `swi_inject` when the hit that caused the break came with `opcode_fetch` = 1. It stays 0 for an operand hit or a software request.
- R7: A control write with bit 1 = 1 creates a break request with no address hit.
- R8: With the pulse, `vector_addr` is 0xFEFC if `monitor_mode` was 1 at the taking edge and 0xFFFC otherwise. It holds that value until the next break is taken.
- R9: `in_break` rises with `swi_inject` and falls the cycle after `rti_done` is sampled high. `flag_clr_allow` is 0 only while `in_break` = 1 and flag-clear-enable = 0.
- R10: While a request is pending or `in_break` = 1, hits and software requests are ignored, so one request gives exactly one pulse.
- R11: A control write with bit 1 = 0 clears break-active and cancels a pending request that has not yet been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at `reg_addr` |
| cpu_addr | input | 16 | Core address bus |
| cpu_addr_valid | input | 1 | Core drives a generated address this cycle |
| opcode_fetch | input | 1 | Current address is an opcode fetch of the next instruction |
| instr_end | input | 1 | Current instruction completes this cycle (boundary) |
| rti_done | input | 1 | Return from the break routine executed |
| monitor_mode | input | 1 | Core is in monitor mode |
| swi_inject | output | 1 | One-cycle request to inject the software-interrupt opcode |
| resume_at_fetch | output | 1 | Break came from an opcode hit; the fetched instruction is dropped |
| vector_addr | output | 16 | Address of the break vector pair |
| in_break | output | 1 | Break state active |
| flag_clr_allow | output | 1 | Status-clearing side effects permitted |

## Verification
Embedded properties check on every cycle that each injection pulse lasts one cycle and follows a sampled boundary. They also check that the vector is one of the two legal values, that the fetch marker never appears without the pulse, that break state is entered only through a pulse, and that a cancelling write with no hit suppresses the pulse. Other behaviours depend on register contents and on event order: the byte-wise comparison with near-miss addresses, the disabled unit, the choice of vector by mode, the opcode-versus-operand marker, cancellation of a pending request, and re-entry blocked by a held matching address. Only the bench scenarios show these, with a reference model compared against the outputs every cycle.

// File: rtl/abp_pkg.sv
package abp_pkg;

    // control register bit positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_ACT_BIT = 1;
    localparam int CTRL_FCE_BIT = 2;

    typedef enum logic {
        KIND_OTHER  = 1'b0,
        KIND_OPCODE = 1'b1
    } brk_kind_e;

    typedef struct packed {
        logic      valid;
        brk_kind_e kind;
    } brk_req_t;

    typedef struct packed {
        logic fce;
        logic enable;
    } ctrl_cfg_t;

    function automatic brk_kind_e kind_of(input logic is_opcode);
        return is_opcode ? KIND_OPCODE : KIND_OTHER;
    endfunction

endpackage

// File: rtl/abp_cmp.sv
module abp_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         eq
);
    assign eq = (lhs == rhs);
endmodule

// File: rtl/abp_regs.sv
module abp_regs
    import abp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SLICE_W = 8,
    parameter int REG_AW  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [SLICE_W-1:0] wdata,
    input  logic               active,
    output logic [ADDR_W-1:0]  brk_addr,
    output ctrl_cfg_t          cfg,
    output logic               ctrl_wr,
    output logic               ctrl_wr_active,
    output logic [SLICE_W-1:0] rdata
);
    localparam int NUM_SLICES = ADDR_W / SLICE_W;
    localparam logic [REG_AW-1:0] CTRL_IDX = REG_AW'(NUM_SLICES);

    logic [SLICE_W-1:0] slice_q [NUM_SLICES];

    assign ctrl_wr        = wr_en && (reg_addr == CTRL_IDX);
    assign ctrl_wr_active = wdata[CTRL_ACT_BIT];

    // slice s = 0 is the low byte; the high byte sits at offset 0
    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        localparam logic [REG_AW-1:0] SLICE_IDX = REG_AW'(NUM_SLICES - 1 - s);
        always_ff @(posedge clk) begin
            if (rst) begin
                slice_q[s] <= '0;
            end else if (wr_en && reg_addr == SLICE_IDX) begin
                slice_q[s] <= wdata;
            end
        end
        assign brk_addr[s*SLICE_W +: SLICE_W] = slice_q[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (ctrl_wr) begin
            cfg.enable <= wdata[CTRL_EN_BIT];
            cfg.fce    <= wdata[CTRL_FCE_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < NUM_SLICES; s++) begin
            if (reg_addr == REG_AW'(NUM_SLICES - 1 - s)) begin
                rdata = slice_q[s];
            end
        end
        if (reg_addr == CTRL_IDX) begin
            rdata[CTRL_EN_BIT]  = cfg.enable;
            rdata[CTRL_ACT_BIT] = active;
            rdata[CTRL_FCE_BIT] = cfg.fce;
        end
    end
endmodule

// File: rtl/abp_ctrl.sv
module abp_ctrl
    import abp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_NORM = 16'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_MON  = 16'hFEFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              opcode_fetch,
    input  logic              instr_end,
    input  logic              rti_done,
    input  logic              monitor_mode,
    input  logic              ctrl_wr,
    input  logic              ctrl_wr_active,
    output logic              active,
    output logic              swi_inject,
    output logic              resume_at_fetch,
    output logic [ADDR_W-1:0] vector_addr,
    output logic              in_break
);
    brk_req_t  pend_q;
    logic      busy, new_hit, new_sw, cancel, pend_live, req_now, take;
    brk_kind_e kind_now, kind_take;

    always_comb begin
        busy      = in_break | pend_q.valid;
        new_hit   = hit & ~busy;
        new_sw    = ctrl_wr & ctrl_wr_active & ~busy;
        cancel    = ctrl_wr & ~ctrl_wr_active;
        pend_live = pend_q.valid & ~cancel;
        req_now   = new_hit | new_sw;
        kind_now  = kind_of(new_hit & opcode_fetch);
        kind_take = pend_live ? pend_q.kind : kind_now;
        take      = instr_end & ~in_break & (pend_live | req_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q          <= '0;
            in_break        <= 1'b0;
            swi_inject      <= 1'b0;
            resume_at_fetch <= 1'b0;
            vector_addr     <= VEC_NORM;
            active          <= 1'b0;
        end else begin
            swi_inject      <= take;
            resume_at_fetch <= take && (kind_take == KIND_OPCODE);
            if (take) begin
                vector_addr <= monitor_mode ? VEC_MON : VEC_NORM;
            end
            if (take) begin
                pend_q <= '0;
            end else if (req_now) begin
                pend_q.valid <= 1'b1;
                pend_q.kind  <= kind_now;
            end else if (cancel) begin
                pend_q <= '0;
            end
            if (take) begin
                in_break <= 1'b1;
            end else if (in_break && rti_done) begin
                in_break <= 1'b0;
            end
            if (new_hit) begin
                active <= 1'b1;
            end else if (ctrl_wr) begin
                active <= ctrl_wr_active;
            end
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        swi_inject |=> !swi_inject);
    a_r5_at_boundary: assert property (@(posedge clk) disable iff (rst)
        swi_inject |-> $past(instr_end));
    a_r6_marker_with_pulse: assert property (@(posedge clk) disable iff (rst)
        resume_at_fetch |-> swi_inject);
    a_r8_vector_legal: assert property (@(posedge clk) disable iff (rst)
        swi_inject |-> (vector_addr == VEC_NORM || vector_addr == VEC_MON));
    a_r9_enter_by_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(in_break) |-> swi_inject);
    a_r10_no_reentry: assert property (@(posedge clk) disable iff (rst)
        (in_break && $past(in_break)) |-> !swi_inject);
    a_r11_cancel_blocks: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_wr_active && !hit) |=> !swi_inject);
endmodule

// File: rtl/addr_brkpt_unit.sv
module addr_brkpt_unit
    import abp_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                SLICE_W  = 8,
    parameter int                REG_AW   = 2,
    parameter logic [ADDR_W-1:0] VEC_NORM = 16'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_MON  = 16'hFEFC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [SLICE_W-1:0] reg_wdata,
    output logic [SLICE_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_addr_valid,
    input  logic               opcode_fetch,
    input  logic               instr_end,
    input  logic               rti_done,
    input  logic               monitor_mode,
    output logic               swi_inject,
    output logic               resume_at_fetch,
    output logic [ADDR_W-1:0]  vector_addr,
    output logic               in_break,
    output logic               flag_clr_allow
);
    localparam int NUM_SLICES = ADDR_W / SLICE_W;

    logic [ADDR_W-1:0]     brk_addr;
    ctrl_cfg_t             cfg;
    logic                  ctrl_wr, ctrl_wr_active, active, hit;
    logic [NUM_SLICES-1:0] slice_eq;

    abp_regs #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .reg_addr(reg_addr),
        .wdata(reg_wdata), .active(active), .brk_addr(brk_addr), .cfg(cfg),
        .ctrl_wr(ctrl_wr), .ctrl_wr_active(ctrl_wr_active), .rdata(reg_rdata)
    );

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_cmp
        abp_cmp #(.W(SLICE_W)) u_cmp (
            .lhs(cpu_addr[s*SLICE_W +: SLICE_W]),
            .rhs(brk_addr[s*SLICE_W +: SLICE_W]),
            .eq (slice_eq[s])
        );
    end

    assign hit = cfg.enable & cpu_addr_valid & (&slice_eq);

    abp_ctrl #(.ADDR_W(ADDR_W), .VEC_NORM(VEC_NORM), .VEC_MON(VEC_MON)) u_ctrl (
        .clk(clk), .rst(rst), .hit(hit), .opcode_fetch(opcode_fetch),
        .instr_end(instr_end), .rti_done(rti_done), .monitor_mode(monitor_mode),
        .ctrl_wr(ctrl_wr), .ctrl_wr_active(ctrl_wr_active), .active(active),
        .swi_inject(swi_inject), .resume_at_fetch(resume_at_fetch),
        .vector_addr(vector_addr), .in_break(in_break)
    );

    assign flag_clr_allow = ~in_break | cfg.fce;

    a_r4_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        (!cfg.enable && !ctrl_wr && !active) |=> !active);
endmodule

// File: tb/tb_addr_brkpt_unit.sv
module tb_addr_brkpt_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  raddr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [15:0] caddr = 16'd0;
    logic        av = 1'b0, opf = 1'b0, ie = 1'b0, rti = 1'b0, mon = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] vec;
    logic        swi, res, inb, fca;

    int total = 0, bad = 0, swi_cnt = 0, res_cnt = 0;
    bit started = 0, finished = 0;

    always #2.5 clk = ~clk;

    addr_brkpt_unit dut (
        .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_addr(raddr),
        .reg_wdata(wdata), .reg_rdata(rdata), .cpu_addr(caddr),
        .cpu_addr_valid(av), .opcode_fetch(opf), .instr_end(ie),
        .rti_done(rti), .monitor_mode(mon), .swi_inject(swi),
        .resume_at_fetch(res), .vector_addr(vec), .in_break(inb),
        .flag_clr_allow(fca)
    );

    // behavioural reference model
    logic [7:0]  m_hi, m_lo;
    logic        m_en, m_fce, m_act, m_pend, m_kop, m_inb, m_swi, m_res;
    logic [15:0] m_vec;

    always @(posedge clk) begin : model
        bit wr_c, hitv, freev, nh, ns, rq, kn, canc, pl, tk;
        started = 1;
        if (rst) begin
            m_hi = 0; m_lo = 0; m_en = 0; m_fce = 0; m_act = 0; m_pend = 0;
            m_kop = 0; m_inb = 0; m_swi = 0; m_res = 0; m_vec = 16'hFFFC;
        end else begin
            wr_c  = wr_en && raddr == 2'd2;
            hitv  = m_en && av && caddr == {m_hi, m_lo};
            freev = !m_inb && !m_pend;
            nh    = hitv && freev;
            ns    = wr_c && wdata[1] && freev;
            rq    = nh || ns;
            kn    = nh && opf;
            canc  = wr_c && !wdata[1];
            pl    = m_pend && !canc;
            tk    = ie && !m_inb && (pl || rq);
            m_swi = tk;
            m_res = tk && (pl ? m_kop : kn);
            if (tk) m_vec = mon ? 16'hFEFC : 16'hFFFC;
            if (tk) m_pend = 0;
            else if (rq) begin m_pend = 1; m_kop = kn; end
            else if (canc) m_pend = 0;
            if (tk) m_inb = 1;
            else if (m_inb && rti) m_inb = 0;
            if (wr_c) m_act = wdata[1];
            if (nh) m_act = 1;
            if (wr_en && raddr == 2'd0) m_hi = wdata;
            if (wr_en && raddr == 2'd1) m_lo = wdata;
            if (wr_c) begin m_en = wdata[0]; m_fce = wdata[2]; end
        end
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_hi;
            2'd1: return m_lo;
            2'd2: return {5'd0, m_fce, m_act, m_en};
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(swi == m_swi, "R5 swi_inject", swi, m_swi);
            chk(res == m_res, "R6 resume_at_fetch", res, m_res);
            chk(vec == m_vec, "R8 vector_addr", vec, m_vec);
            chk(inb == m_inb, "R9 in_break", inb, m_inb);
            chk(fca == (!m_inb || m_fce), "R9 flag_clr_allow", fca, !m_inb || m_fce);
            chk(rdata == exp_rd(raddr), "R2 reg_rdata", rdata, exp_rd(raddr));
            if (swi) swi_cnt++;
            if (res) res_cnt++;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; raddr = a; wdata = d; tick(); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        raddr = a; #0.5; v = rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin : stim
        logic [7:0] v;
        int c0;
        tick(3);
        rst = 0;
        tick();
        // R1 reset state
        chk(swi == 0 && res == 0 && inb == 0, "R1 outputs idle", {swi, res, inb}, 0);
        chk(fca == 1, "R1 flag_clr_allow", fca, 1);
        chk(vec == 16'hFFFC, "R1 vector", vec, 16'hFFFC);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk(v == 0, "R1 register clear", v, 0);
        end
        // R2 program and read back
        wr(0, 8'h12); wr(1, 8'h34); wr(3, 8'hFF); wr(2, 8'hF9);
        rd(0, v); chk(v == 8'h12, "R2 high byte", v, 8'h12);
        rd(1, v); chk(v == 8'h34, "R2 low byte", v, 8'h34);
        rd(2, v); chk(v == 8'h01, "R2 control upper bits zero", v, 8'h01);
        rd(3, v); chk(v == 8'h00, "R2 offset 3 reads zero", v, 0);
        // R3 R5 R6 operand hit, taken at a later boundary
        caddr = 16'h1234; av = 1; opf = 0; tick(); av = 0;
        tick(2);
        chk(swi_cnt == 0, "R5 waits for boundary", swi_cnt, 0);
        rd(2, v); chk(v[1] == 1, "R3 hit sets active", v[1], 1);
        ie = 1; tick(); ie = 0; tick();
        chk(swi_cnt == 1, "R5 one pulse", swi_cnt, 1);
        chk(res_cnt == 0, "R6 operand hit marker low", res_cnt, 0);
        chk(vec == 16'hFFFC, "R8 normal vector", vec, 16'hFFFC);
        chk(inb == 1 && fca == 0, "R9 break blocks clears", {inb, fca}, 2'b10);
        // R10 hit and boundary while in break
        av = 1; ie = 1; tick(3); av = 0; ie = 0; tick();
        chk(swi_cnt == 1, "R10 no reentry", swi_cnt, 1);
        rti = 1; tick(); rti = 0; tick();
        chk(inb == 0, "R9 rti ends break", inb, 0);
        wr(2, 8'h01);
        // R6 opcode hit on the boundary cycle
        av = 1; opf = 1; ie = 1; tick(); av = 0; opf = 0; ie = 0; tick();
        chk(swi_cnt == 2 && res_cnt == 1, "R6 opcode hit marker", res_cnt, 1);
        rti = 1; tick(); rti = 0; wr(2, 8'h01);
        // R3 near misses in each byte
        caddr = 16'h1235; av = 1; ie = 1; tick(2);
        caddr = 16'h1334; tick(2); av = 0; ie = 0; tick();
        chk(swi_cnt == 2, "R3 near miss no break", swi_cnt, 2);
        rd(2, v); chk(v[1] == 0, "R3 near miss active clear", v[1], 0);
        // R4 disabled
        wr(2, 8'h00);
        caddr = 16'h1234; av = 1; ie = 1; tick(3); av = 0; ie = 0; tick();
        chk(swi_cnt == 2, "R4 disabled no break", swi_cnt, 2);
        rd(2, v); chk(v[1] == 0, "R4 active stays clear", v[1], 0);
        // R7 R8 software request in monitor mode
        mon = 1; wr(2, 8'h02); tick();
        chk(swi_cnt == 2, "R7 waits for boundary", swi_cnt, 2);
        ie = 1; tick(); ie = 0; tick();
        chk(swi_cnt == 3 && res_cnt == 1, "R7 forced break", swi_cnt, 3);
        chk(vec == 16'hFEFC, "R8 monitor vector", vec, 16'hFEFC);
        mon = 0; rti = 1; tick(); rti = 0; tick();
        chk(vec == 16'hFEFC, "R8 vector held", vec, 16'hFEFC);
        // R11 cancel a pending request
        wr(2, 8'h01);
        av = 1; tick(); av = 0;
        wr(2, 8'h01);
        ie = 1; tick(2); ie = 0; tick();
        chk(swi_cnt == 3, "R11 cancel drops request", swi_cnt, 3);
        rd(2, v); chk(v[1] == 0, "R11 active cleared", v[1], 0);
        // R10 held hit gives one pulse; R9 flag-clear-enable
        wr(2, 8'h05);
        c0 = swi_cnt;
        av = 1; tick(4); ie = 1; tick(4); av = 0; ie = 0; tick();
        chk(swi_cnt == c0 + 1, "R10 one pulse per request", swi_cnt, c0 + 1);
        chk(inb == 1 && fca == 1, "R9 fce allows clears", {inb, fca}, 2'b11);
        rti = 1; tick(); rti = 0; tick(2);
        finish_run();
    end
endmodule